// File: doc/BRIEF.md
# Converter Output Test Pattern Generator

This block sits in front of the digital output lanes of a two-channel data converter. It serves four 12-bit data lanes, a direct lane and a delayed lane for each of channels A and B, and one out-of-range flag per channel. While the pattern enable is low, every lane and flag is a registered copy of the live sample data. While it is high, the block puts a known word sequence on all lanes and flags. A receiver can then check lane mapping, bit order and capture timing without an analog input.

Each lane has its own base word. The frame is ten clocks long. The first five steps carry the base word and the last five carry its bitwise complement. The out-of-range flags toggle 0,1,0,1,0 within each half-frame. The demux select picks how many lanes carry the pattern. Powering down a channel blanks that channel's pattern output.

Top module: `adc_tpat_gen`

## Requirements
- R1: While reset is active, all data lanes and both flags are zero, and the frame step is 0.
- R2: With the pattern enable low, each output lane and flag equals the matching live input one clock earlier.
- R3: With the pattern enable high, demux select high and both channels powered up, the lanes carry base words at steps 0-4 and their complements at steps 5-9. The base words are: channel A direct 010h, channel A delayed FEFh, channel B direct 008h, channel B delayed FF7h.
- R4: The frame step starts at 0 on the first enabled clock, advances by one on every enabled clock, and wraps from 9 to 0. The frame repeats without end.
- R5: In pattern mode, a powered-up channel's flag is 1 at steps 1, 3, 6 and 8 and 0 at every other step. The live flag inputs have no effect.
- R6: In pattern mode with demux select low, both delayed lanes output zero and the direct lanes still carry their pattern.
- R7: In pattern mode, a powered-down channel drives zero on both of its lanes and its flag. The other channel is unaffected.
- R8: Dropping the pattern enable returns the outputs to live data on the next clock and resets the step. The next enable starts again at step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_en | input | 1 | Pattern enable |
| demux_sel | input | 1 | 1: pattern on all four lanes; 0: direct lanes only |
| pwrdn_a | input | 1 | Channel A powered down |
| pwrdn_b | input | 1 | Channel B powered down |
| live_a | input | 12 | Live data, channel A direct lane |
| live_a_dly | input | 12 | Live data, channel A delayed lane |
| live_b | input | 12 | Live data, channel B direct lane |
| live_b_dly | input | 12 | Live data, channel B delayed lane |
| live_ovr_a | input | 1 | Live out-of-range flag, channel A |
| live_ovr_b | input | 1 | Live out-of-range flag, channel B |
| out_a | output | 12 | Output lane, channel A direct |
| out_a_dly | output | 12 | Output lane, channel A delayed |
| out_b | output | 12 | Output lane, channel B direct |
| out_b_dly | output | 12 | Output lane, channel B delayed |
| ovr_a | output | 1 | Out-of-range output, channel A |
| ovr_b | output | 1 | Out-of-range output, channel B |

## Verification
The hardest case to reach from the ports is a pattern enable that is dropped partway through a frame and then raised again. A step counter that fails to clear shows only as a shifted phase, and only on the next enable. The bench sweeps all eight combinations of demux select and the two power-down bits. Each run lasts more than two frames, so the 9-to-0 wrap is covered. Between runs the bench inserts short enable bursts that end mid-frame. It checks every lane on every clock against a step count kept in the bench, and drives random live data, including the flags, throughout.

// File: rtl/adc_tpat_gen.sv
`timescale 1ns/1ps
module adc_tpat_gen #(
  parameter int DW        = 12,
  parameter int FRAME_LEN = 10,
  parameter logic [DW-1:0] W_A     = 12'h010,
  parameter logic [DW-1:0] W_A_DLY = 12'hFEF,
  parameter logic [DW-1:0] W_B     = 12'h008,
  parameter logic [DW-1:0] W_B_DLY = 12'hFF7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pat_en,
  input  logic          demux_sel,
  input  logic          pwrdn_a,
  input  logic          pwrdn_b,
  input  logic [DW-1:0] live_a,
  input  logic [DW-1:0] live_a_dly,
  input  logic [DW-1:0] live_b,
  input  logic [DW-1:0] live_b_dly,
  input  logic          live_ovr_a,
  input  logic          live_ovr_b,
  output logic [DW-1:0] out_a,
  output logic [DW-1:0] out_a_dly,
  output logic [DW-1:0] out_b,
  output logic [DW-1:0] out_b_dly,
  output logic          ovr_a,
  output logic          ovr_b
);
  localparam int HALF = FRAME_LEN / 2;
  localparam int SW   = $clog2(FRAME_LEN);
  localparam logic [SW-1:0] LAST  = SW'(FRAME_LEN - 1);
  localparam logic [SW-1:0] HALFS = SW'(HALF);

  logic [SW-1:0] step;
  logic          inv;
  logic [SW-1:0] pos;
  logic          flag_pat;

  assign inv      = step >= HALFS;
  assign pos      = inv ? step - HALFS : step;
  assign flag_pat = pos[0];

  logic [DW-1:0] pw_a, pw_a_dly, pw_b, pw_b_dly;
  assign pw_a     = inv ? ~W_A     : W_A;
  assign pw_a_dly = inv ? ~W_A_DLY : W_A_DLY;
  assign pw_b     = inv ? ~W_B     : W_B;
  assign pw_b_dly = inv ? ~W_B_DLY : W_B_DLY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= '0;
      out_a     <= '0;
      out_a_dly <= '0;
      out_b     <= '0;
      out_b_dly <= '0;
      ovr_a     <= 1'b0;
      ovr_b     <= 1'b0;
    end else if (pat_en) begin
      step      <= (step == LAST) ? '0 : step + 1'b1;
      out_a     <= pwrdn_a ? '0 : pw_a;
      out_b     <= pwrdn_b ? '0 : pw_b;
      out_a_dly <= (pwrdn_a || !demux_sel) ? '0 : pw_a_dly;
      out_b_dly <= (pwrdn_b || !demux_sel) ? '0 : pw_b_dly;
      ovr_a     <= !pwrdn_a && flag_pat;
      ovr_b     <= !pwrdn_b && flag_pat;
    end else begin
      step      <= '0;
      out_a     <= live_a;
      out_a_dly <= live_a_dly;
      out_b     <= live_b;
      out_b_dly <= live_b_dly;
      ovr_a     <= live_ovr_a;
      ovr_b     <= live_ovr_b;
    end
  end
endmodule

// File: rtl/adc_tpat_gen_chk.sv
`timescale 1ns/1ps
module adc_tpat_gen_chk #(
  parameter int DW = 12,
  parameter int SW = 4,
  parameter int FRAME_LEN = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pat_en,
  input logic          demux_sel,
  input logic          pwrdn_a,
  input logic          pwrdn_b,
  input logic [DW-1:0] live_a,
  input logic          live_ovr_b,
  input logic [DW-1:0] out_a,
  input logic [DW-1:0] out_a_dly,
  input logic [DW-1:0] out_b_dly,
  input logic          ovr_a,
  input logic          ovr_b,
  input logic [SW-1:0] step
);
  // R2
  live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_en |=> (out_a == $past(live_a) && ovr_b == $past(live_ovr_b)));
  // R3
  lane_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && demux_sel && !pwrdn_a) |=> (out_a == ~out_a_dly));
  // R4
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && step == SW'(FRAME_LEN - 1)) |=> step == '0);
  // R4
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step < SW'(FRAME_LEN));
  // R5
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && !pwrdn_a && !pwrdn_b) |=> ovr_a == ovr_b);
  // R6
  dly_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && !demux_sel) |=> (out_a_dly == '0 && out_b_dly == '0));
  // R7
  pwrdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_en && pwrdn_a) |=> (out_a == '0 && out_a_dly == '0 && !ovr_a));
  // R8
  step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_en |=> step == '0);
endmodule

bind adc_tpat_gen adc_tpat_gen_chk #(.DW(DW), .SW(SW), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pat_en(pat_en), .demux_sel(demux_sel),
  .pwrdn_a(pwrdn_a), .pwrdn_b(pwrdn_b), .live_a(live_a), .live_ovr_b(live_ovr_b),
  .out_a(out_a), .out_a_dly(out_a_dly), .out_b_dly(out_b_dly),
  .ovr_a(ovr_a), .ovr_b(ovr_b), .step(step));

// File: tb/adc_tpat_gen_tb.sv
`timescale 1ns/1ps
module adc_tpat_gen_tb;
  logic clk = 0, rst_n = 0, pat_en = 0, demux_sel = 0, pwrdn_a = 0, pwrdn_b = 0;
  logic [11:0] live_a = 0, live_a_dly = 0, live_b = 0, live_b_dly = 0;
  logic live_ovr_a = 0, live_ovr_b = 0;
  logic [11:0] out_a, out_a_dly, out_b, out_b_dly;
  logic ovr_a, ovr_b;
  int checks = 0, fails = 0, mstep = 0;
  logic [11:0] e_a, e_ad, e_b, e_bd;
  logic e_oa, e_ob;
  string tag;

  always #2 clk = ~clk;

  adc_tpat_gen u_dut (.*);

  task automatic chk(string req, string what, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s step=%0d actual=%h expected=%h", req, what, mstep, act, exp);
    end
  endtask

  function automatic logic [11:0] word(logic [11:0] base, int s);
    return (s >= 5) ? ~base : base;
  endfunction

  task automatic cycle();
    live_a = 12'($urandom); live_a_dly = 12'($urandom);
    live_b = 12'($urandom); live_b_dly = 12'($urandom);
    live_ovr_a = 1'($urandom); live_ovr_b = 1'($urandom);
    if (pat_en) begin
      logic fl;
      fl = ((mstep % 5) % 2) == 1;
      e_a  = pwrdn_a ? 12'h0 : word(12'h010, mstep);
      e_b  = pwrdn_b ? 12'h0 : word(12'h008, mstep);
      e_ad = (pwrdn_a || !demux_sel) ? 12'h0 : word(12'hFEF, mstep);
      e_bd = (pwrdn_b || !demux_sel) ? 12'h0 : word(12'hFF7, mstep);
      e_oa = !pwrdn_a && fl;
      e_ob = !pwrdn_b && fl;
      tag = (pwrdn_a || pwrdn_b) ? "R7" : (!demux_sel ? "R6" : "R3/R4");
    end else begin
      e_a = live_a; e_ad = live_a_dly; e_b = live_b; e_bd = live_b_dly;
      e_oa = live_ovr_a; e_ob = live_ovr_b;
      tag = "R2/R8";
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "out_a", out_a, e_a);
    chk(tag, "out_a_dly", out_a_dly, e_ad);
    chk(tag, "out_b", out_b, e_b);
    chk(tag, "out_b_dly", out_b_dly, e_bd);
    chk(pat_en ? "R5" : "R2", "ovr_a", {11'b0, ovr_a}, {11'b0, e_oa});
    chk(pat_en ? "R5" : "R2", "ovr_b", {11'b0, ovr_b}, {11'b0, e_ob});
    mstep = pat_en ? (mstep + 1) % 10 : 0;
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_a", out_a, 0);
    chk("R1", "out_a_dly", out_a_dly, 0);
    chk("R1", "out_b", out_b, 0);
    chk("R1", "out_b_dly", out_b_dly, 0);
    chk("R1", "flags", {10'b0, ovr_a, ovr_b}, 0);
    rst_n = 1;
    repeat (6) cycle();
    for (int cfg = 0; cfg < 8; cfg++) begin
      demux_sel = cfg[0]; pwrdn_a = cfg[1]; pwrdn_b = cfg[2];
      pat_en = 1;
      repeat (23) cycle();
      pat_en = 0;
      cycle();
      pat_en = 1;
      repeat (3 + cfg) cycle();
      pat_en = 0;
      repeat (2) cycle();
    end
    demux_sel = 1; pwrdn_a = 0; pwrdn_b = 0;
    for (int burst = 1; burst < 12; burst++) begin
      pat_en = 1;
      repeat (burst) cycle();
      pat_en = 0;
      cycle();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule